// File: doc/BRIEF.md
# Output Trigger and Gate Conditioner

This block sits in front of an analog-output engine. It turns a bank of timing lines into three control signals: a start pulse, an update pulse and a gate level. The timing lines can be external pins that are already synchronised, or outputs of neighbouring engines. Each control path has its own 6-bit source code. Code 0 on a path picks a dedicated input: the software start strobe, the internal interval-counter terminal count, or "no gating" on the gate path. Code 31 picks a constant low. Codes 1 to `N_LINES-1` pick `line_bus[code]`. All other codes route a constant 0.

Each selected signal is first XORed with its polarity bit. The start and update paths then pass through an edge-detect state machine, which has three states:
- `ES_SEED`: entered at reset. It learns the first level without firing.
- `ES_LOW`: the adjusted signal was low on the previous clock.
- `ES_HIGH`: the adjusted signal was high on the previous clock.

The transitions are:
- seed-to-low and seed-to-high: taken on the first clock after reset.
- low-to-high: the firing transition, which marks a qualifying edge.
- high-to-low: a re-arm.
- low-to-low and high-to-high: holds.

The start path can bypass edge detection and pass the adjusted level instead. All three outputs are registered, so each appears one clock after the edge at which its input is sampled.

Top module: `trig_gate_cond`

## Requirements
- R1: With `start_sel` = 0 the start path takes `sw_start`. With `start_sel` = k, for 1 <= k < `N_LINES` and k != 31, it takes `line_bus[k]`. Lines that are not selected have no effect on `start_pulse`.
- R2: Code 31 on any select routes a constant 0, and so does any code >= `N_LINES`. Neither produces a start or update pulse, and on the gate path either one reads as a low gate input.
- R3: With `start_edge_en` = 1, `start_pulse` is high for exactly one clock per qualifying edge. When `start_pol` = 0 a rising edge qualifies, and when `start_pol` = 1 a falling edge qualifies. The pulse appears in the clock after the edge that first samples the new level.
- R4: With `start_edge_en` = 0, `start_pulse` equals the selected level XOR `start_pol`, delayed by one clock, and stays high for as long as that value is 1.
- R5: With `upd_sel` = 0 the update path takes `int_tc`; with any other code it takes the routed line. `upd_pol` = 0 fires on a rising edge and 1 on a falling edge. In internal mode `upd_pol` is expected to be 0.
- R6: `update_pulse` is one clock wide per qualifying edge. An input held at its active level produces no further pulses.
- R7: With `gate_en` = 1 and `gate_sel` != 0, `gate_ok` equals the routed gate line XOR `gate_pol`, one clock later. `gate_pol` = 0 means the gate is open while the line is high.
- R8: With `gate_en` = 0, or with `gate_sel` = 0, `gate_ok` is 1 one clock later.
- R9: An update edge that occurs while the gate is closed produces no `update_pulse`. `start_pulse` never depends on the gate.
- R10: While `rst_n` is low all three outputs are 0. The first clock after reset only seeds the edge detectors, so a line that is already at its active level at reset release produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_bus | input | N_LINES | Synchronised timing lines, indexed by source code |
| sw_start | input | 1 | Software start strobe, used by start code 0 |
| int_tc | input | 1 | Interval-counter terminal count, used by update code 0 |
| start_sel | input | SEL_W | Start source code |
| start_pol | input | 1 | Start polarity: 0 rising or high, 1 falling or low |
| start_edge_en | input | 1 | 1 selects edge detection on the start path, 0 selects level |
| upd_sel | input | SEL_W | Update source code; 0 selects internal mode |
| upd_pol | input | 1 | Update polarity: 0 rising, 1 falling |
| gate_en | input | 1 | Enables external gating |
| gate_pol | input | 1 | Gate polarity: 0 active high, 1 active low |
| gate_sel | input | SEL_W | Gate source code; 0 disables the gate |
| start_pulse | output | 1 | Registered start pulse, or start level in level mode |
| update_pulse | output | 1 | Registered one-clock update pulse |
| gate_ok | output | 1 | Registered gate-open level |

## Verification
The bench aims at the source codes that must not route a line: 0, 31 and codes at or above `N_LINES`. A decoder that passed `line_bus[code]` straight through would fire from the constant-low code or from an out-of-range code. Falling-edge polarity is exercised on both the start and update paths, so a polarity that is ignored or applied after the edge detector gives a pulse on the wrong transition. The bench also checks the following:
- A held active level is sampled over several clocks. This exposes an edge detector that degrades to level following.
- A closed gate must swallow an update edge while still letting the start pulse through.
- A line held high across reset release must not fire. An unseeded detector would emit a spurious pulse in the first clock.

// File: rtl/tgc_pkg.sv
package tgc_pkg;
    // edge detector states
    typedef enum logic [1:0] {
        ES_SEED = 2'd0,
        ES_LOW  = 2'd1,
        ES_HIGH = 2'd2
    } edge_st_t;

    // source code that routes a constant low on every path
    localparam int LOW_CODE = 31;
endpackage

// File: rtl/tgc_src_mux.sv
module tgc_src_mux #(
    parameter int N_LINES = 48,
    parameter int SEL_W   = 6
) (
    input  logic [N_LINES-1:0] lines,
    input  logic [SEL_W-1:0]   sel,
    input  logic               code0_val,
    output logic               sig
);
    import tgc_pkg::*;

    localparam logic [SEL_W-1:0] LOW_SEL = SEL_W'(LOW_CODE);

    always_comb begin
        sig = 1'b0;
        for (int i = 0; i < N_LINES; i++) begin
            if (sel == SEL_W'(i)) sig = lines[i];
        end
        if (sel == LOW_SEL) sig = 1'b0;
        if (sel == '0)      sig = code0_val;
    end
endmodule

// File: rtl/tgc_edge_fsm.sv
module tgc_edge_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fire
);
    import tgc_pkg::*;

    edge_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ES_SEED: st_d = lvl ? ES_HIGH : ES_LOW;
            ES_LOW:  st_d = lvl ? ES_HIGH : ES_LOW;
            ES_HIGH: st_d = lvl ? ES_HIGH : ES_LOW;
            default: st_d = ES_SEED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ES_SEED;
        else        st_q <= st_d;
    end

    // output process: fire only on the low-to-high transition
    always_comb begin
        fire = 1'b0;
        unique case (st_q)
            ES_SEED: fire = 1'b0;
            ES_LOW:  fire = lvl;
            ES_HIGH: fire = 1'b0;
            default: fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/trig_gate_cond.sv
module trig_gate_cond #(
    parameter int N_LINES = 48,
    parameter int SEL_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] line_bus,
    input  logic               sw_start,
    input  logic               int_tc,
    input  logic [SEL_W-1:0]   start_sel,
    input  logic               start_pol,
    input  logic               start_edge_en,
    input  logic [SEL_W-1:0]   upd_sel,
    input  logic               upd_pol,
    input  logic               gate_en,
    input  logic               gate_pol,
    input  logic [SEL_W-1:0]   gate_sel,
    output logic               start_pulse,
    output logic               update_pulse,
    output logic               gate_ok
);
    logic st_raw, up_raw, gt_raw;
    logic st_lvl, up_lvl;
    logic st_fire, up_fire;
    logic gate_open;

    tgc_src_mux #(.N_LINES(N_LINES), .SEL_W(SEL_W)) u_st_mux (
        .lines(line_bus), .sel(start_sel), .code0_val(sw_start), .sig(st_raw));
    tgc_src_mux #(.N_LINES(N_LINES), .SEL_W(SEL_W)) u_up_mux (
        .lines(line_bus), .sel(upd_sel), .code0_val(int_tc), .sig(up_raw));
    tgc_src_mux #(.N_LINES(N_LINES), .SEL_W(SEL_W)) u_gt_mux (
        .lines(line_bus), .sel(gate_sel), .code0_val(1'b0), .sig(gt_raw));

    assign st_lvl = st_raw ^ start_pol;
    assign up_lvl = up_raw ^ upd_pol;

    tgc_edge_fsm u_st_edge (.clk(clk), .rst_n(rst_n), .lvl(st_lvl), .fire(st_fire));
    tgc_edge_fsm u_up_edge (.clk(clk), .rst_n(rst_n), .lvl(up_lvl), .fire(up_fire));

    always_comb begin
        gate_open = !gate_en || (gate_sel == '0) || (gt_raw ^ gate_pol);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_pulse  <= 1'b0;
            update_pulse <= 1'b0;
            gate_ok      <= 1'b0;
        end else begin
            start_pulse  <= start_edge_en ? st_fire : st_lvl;
            update_pulse <= up_fire & gate_open;
            gate_ok      <= gate_open;
        end
    end
endmodule

// File: rtl/trig_gate_chk.sv
module trig_gate_chk #(
    parameter int N_LINES = 48,
    parameter int SEL_W   = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_edge_en,
    input logic [SEL_W-1:0] upd_sel,
    input logic             upd_pol,
    input logic             gate_en,
    input logic [SEL_W-1:0] gate_sel,
    input logic             start_pulse,
    input logic             update_pulse,
    input logic             gate_ok
);
    localparam logic [SEL_W-1:0] LOW_SEL = SEL_W'(31);

    // R3
    start_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse && start_edge_en && $past(start_edge_en)) |=> !start_pulse);

    // R6
    update_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        update_pulse |=> !update_pulse);

    // R9
    closed_gate_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_ok |-> !update_pulse);

    // R8
    gate_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_en || gate_sel == '0) |=> gate_ok);

    // R2
    low_code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_sel == LOW_SEL && !upd_pol) |=> !update_pulse);
endmodule

bind trig_gate_cond trig_gate_chk #(.N_LINES(N_LINES), .SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_edge_en(start_edge_en), .upd_sel(upd_sel),
    .upd_pol(upd_pol), .gate_en(gate_en), .gate_sel(gate_sel),
    .start_pulse(start_pulse), .update_pulse(update_pulse), .gate_ok(gate_ok));

// File: tb/sim_trig_gate_cond.sv
module sim_trig_gate_cond;
    localparam int NL = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [NL-1:0] line_bus;
    logic sw_start, int_tc;
    logic [5:0] start_sel, upd_sel, gate_sel;
    logic start_pol, start_edge_en, upd_pol, gate_en, gate_pol;
    logic start_pulse, update_pulse, gate_ok;

    trig_gate_cond #(.N_LINES(NL), .SEL_W(6)) u0 (
        .clk(clk), .rst_n(rst_n), .line_bus(line_bus), .sw_start(sw_start),
        .int_tc(int_tc), .start_sel(start_sel), .start_pol(start_pol),
        .start_edge_en(start_edge_en), .upd_sel(upd_sel), .upd_pol(upd_pol),
        .gate_en(gate_en), .gate_pol(gate_pol), .gate_sel(gate_sel),
        .start_pulse(start_pulse), .update_pulse(update_pulse), .gate_ok(gate_ok));

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [5:0] ssel; logic spol; logic sedge;
        logic [5:0] usel; logic upol;
        logic gen; logic gpol; logic [5:0] gsel;
        logic [5:0] ln; logic tsw; logic ttc; logic pre; logic post;
        logic es; logic eu; logic eg;
        logic [7:0] rq;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t TBL [NV] = '{
        '{6'd5, 1'b0,1'b1, 6'd0, 1'b0, 1'b0,1'b0,6'd0,  6'd5, 1'b0,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b1, 8'd1}, // R1 line 5 rise
        '{6'd5, 1'b0,1'b1, 6'd0, 1'b0, 1'b0,1'b0,6'd0,  6'd6, 1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b1, 8'd1}, // R1 other line
        '{6'd0, 1'b0,1'b1, 6'd0, 1'b0, 1'b0,1'b0,6'd0,  6'd0, 1'b1,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b1, 8'd1}, // R1 software strobe
        '{6'd7, 1'b1,1'b1, 6'd0, 1'b0, 1'b0,1'b0,6'd0,  6'd7, 1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0,1'b1, 8'd3}, // R3 falling fires
        '{6'd7, 1'b1,1'b1, 6'd0, 1'b0, 1'b0,1'b0,6'd0,  6'd7, 1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b1, 8'd3}, // R3 rising ignored
        '{6'd9, 1'b0,1'b0, 6'd0, 1'b0, 1'b0,1'b0,6'd0,  6'd9, 1'b0,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b1, 8'd4}, // R4 level high
        '{6'd9, 1'b1,1'b0, 6'd0, 1'b0, 1'b0,1'b0,6'd0,  6'd9, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1, 8'd4}, // R4 inverted low
        '{6'd31,1'b0,1'b1, 6'd0, 1'b0, 1'b0,1'b0,6'd0,  6'd31,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b1, 8'd2}, // R2 start low code
        '{6'd50,1'b0,1'b1, 6'd0, 1'b0, 1'b0,1'b0,6'd0,  6'd47,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b1, 8'd2}, // R2 start code out of range
        '{6'd0, 1'b0,1'b1, 6'd0, 1'b0, 1'b0,1'b0,6'd0,  6'd0, 1'b0,1'b1,1'b0,1'b1, 1'b0,1'b1,1'b1, 8'd5}, // R5 internal tc
        '{6'd0, 1'b0,1'b1, 6'd12,1'b0, 1'b0,1'b0,6'd0,  6'd12,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b1,1'b1, 8'd5}, // R5 external rise
        '{6'd0, 1'b0,1'b1, 6'd12,1'b1, 1'b0,1'b0,6'd0,  6'd12,1'b0,1'b0,1'b1,1'b0, 1'b0,1'b1,1'b1, 8'd5}, // R5 external fall
        '{6'd0, 1'b0,1'b1, 6'd12,1'b0, 1'b0,1'b0,6'd0,  6'd13,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b1, 8'd5}, // R5 other line
        '{6'd0, 1'b0,1'b1, 6'd31,1'b0, 1'b0,1'b0,6'd0,  6'd31,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b1, 8'd2}, // R2 update low code
        '{6'd0, 1'b0,1'b1, 6'd12,1'b0, 1'b1,1'b1,6'd20, 6'd12,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b1,1'b1, 8'd9}, // R9 gate open (active low)
        '{6'd12,1'b0,1'b1, 6'd12,1'b0, 1'b1,1'b0,6'd20, 6'd12,1'b0,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b0, 8'd9}, // R9 gate closed
        '{6'd0, 1'b0,1'b1, 6'd12,1'b0, 1'b1,1'b0,6'd0,  6'd12,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b1,1'b1, 8'd8}, // R8 gate code 0
        '{6'd0, 1'b0,1'b1, 6'd12,1'b0, 1'b0,1'b0,6'd20, 6'd12,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b1,1'b1, 8'd8}, // R8 gating off
        '{6'd0, 1'b0,1'b1, 6'd12,1'b0, 1'b1,1'b0,6'd31, 6'd12,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0, 8'd2}, // R2 gate low code
        '{6'd0, 1'b0,1'b1, 6'd0, 1'b0, 1'b1,1'b0,6'd20, 6'd20,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b1, 8'd7}, // R7 gate follows line
        '{6'd0, 1'b0,1'b1, 6'd50,1'b0, 1'b0,1'b0,6'd0,  6'd47,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b1, 8'd2}  // R2 update code out of range
    };

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic val);
        line_bus = '0;
        line_bus[v.ln] = val;
        sw_start = v.tsw ? val : 1'b0;
        int_tc   = v.ttc ? val : 1'b0;
    endtask

    task automatic set_cfg(input vec_t v);
        start_sel = v.ssel; start_pol = v.spol; start_edge_en = v.sedge;
        upd_sel = v.usel; upd_pol = v.upol;
        gate_en = v.gen; gate_pol = v.gpol; gate_sel = v.gsel;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog actual running expected finished");
            finish_run();
        end
    end

    initial begin
        line_bus = '0; sw_start = 0; int_tc = 0;
        start_sel = 0; start_pol = 0; start_edge_en = 1;
        upd_sel = 0; upd_pol = 0; gate_en = 0; gate_pol = 0; gate_sel = 0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset start", start_pulse, 1'b0);
        check("R10 reset update", update_pulse, 1'b0);
        check("R10 reset gate", gate_ok, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = TBL[i];
            @(negedge clk);
            set_cfg(v);
            drive(v, v.pre);
            repeat (3) @(negedge clk);
            drive(v, v.post);
            @(negedge clk);
            check($sformatf("R%0d vec %0d start", v.rq, i), start_pulse, v.es);
            check($sformatf("R%0d vec %0d update", v.rq, i), update_pulse, v.eu);
            check($sformatf("R%0d vec %0d gate", v.rq, i), gate_ok, v.eg);
        end

        // R6 and R3: single pulse while the level is held
        line_bus = '0; start_sel = 12; start_pol = 0; start_edge_en = 1;
        upd_sel = 12; upd_pol = 0; gate_en = 0; gate_sel = 0;
        repeat (3) @(negedge clk);
        line_bus[12] = 1'b1;
        @(negedge clk);
        check("R6 update first", update_pulse, 1'b1);
        check("R3 start first", start_pulse, 1'b1);
        @(negedge clk);
        check("R6 update held", update_pulse, 1'b0);
        check("R3 start held", start_pulse, 1'b0);
        @(negedge clk);
        check("R6 update held2", update_pulse, 1'b0);

        // R4: level mode follows a held level
        start_edge_en = 0;
        @(negedge clk);
        check("R4 level held a", start_pulse, 1'b1);
        @(negedge clk);
        check("R4 level held b", start_pulse, 1'b1);
        line_bus[12] = 1'b0;
        @(negedge clk);
        check("R4 level drop", start_pulse, 1'b0);

        // R10: seeding at reset release
        start_edge_en = 1; start_sel = 5; upd_sel = 5;
        line_bus = '0; line_bus[5] = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 in reset start", start_pulse, 1'b0);
        check("R10 in reset gate", gate_ok, 1'b0);
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R10 seed start", start_pulse, 1'b0);
            check("R10 seed update", update_pulse, 1'b0);
        end

        finish_run();
    end
endmodule